// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block keeps two independent 32-bit event counters that software sees as one 64-bit count register, plus a control register that chooses, for each counter, which event it follows and in which privilege modes it may advance. Each cycle the block takes a vector of one-cycle event strobes and a single privilege-mode input. An event that reports more than once in a cycle still adds only one to a counter.

Software preloads a counter through a simple register port to arm an interrupt after a chosen number of events. The interrupt is a level signal that stays high while the top bit of either counter is set. It falls again when software rewrites the counter, or when the counter wraps through zero.

The block has no sequencing state of its own. Each counter is a register with three named transitions, chosen in priority order every cycle: LOAD (software write), STEP (qualified event, +1 with wrap) and HOLD (no change).

Top module: `perf_counter_unit`

## Requirements
- R1: After reset both counters and the control register read as zero, and `irq` is low.
- R2: A write with `reg_addr`=0 loads counter 0 from `reg_wdata[31:0]` and counter 1 from `reg_wdata[63:32]`. A read with `reg_addr`=0 returns counter 1 in bits 63:32 and counter 0 in bits 31:0.
- R3: A write with `reg_addr`=1 sets the control fields from `reg_wdata`:
  - bits 4:0 hold the counter 0 event code;
  - bits 9:5 hold the counter 1 event code;
  - bit 10 is the user enable;
  - bit 11 is the kernel enable;
  - bit 12 is the global enable.
  A read with `reg_addr`=1 returns those bits, and every other bit reads as zero. The new control value governs counting from the next cycle on.
- R4: Event code 0 advances its counter by one in every qualified cycle, whatever the strobes are.
- R5: Any code from 1 to 30, other than 29, advances its counter by exactly one in a qualified cycle in which `ev_strobe[code]` is 1.
- R6: Codes 29 and 31 never advance a counter.
- R7: A cycle is qualified only when the global enable is 1 and, in addition, the kernel enable is 1 while `priv_kernel`=1, or the user enable is 1 while `priv_kernel`=0.
- R8: A count-register write wins over an increment in the same cycle: the written value is stored unchanged.
- R9: `irq` is 1 exactly while bit 31 or bit 63 of the count register is 1.
- R10: A counter at 0xFFFFFFFF that advances becomes 0, and `irq` then drops unless the other counter holds its top bit.
- R11: The two counters are independent: each follows its own event code, and activity on one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_strobe | input | 31 | One-cycle event strobes, bit n for event code n |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = count register, 1 = control register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt, top bit of either counter |

## Verification
The following rules are checked by assertions on every cycle:
- a write beats an increment (R8);
- a counter steps by exactly one or holds (R5);
- the all-ones value wraps to zero (R10);
- the reserved codes never produce a hit (R6);
- the count register freezes while the global enable is off (R7);
- a control write lands next cycle (R3).

The bench scenarios must show what depends on the meaning of codes and fields:
- that the strobe bit used is the one named by the selected code;
- that code 0 ignores the strobes;
- that the privilege filter picks the right enable bit;
- the bit layouts of both registers;
- that `irq` tracks the top bits through preload and wrap.

// File: rtl/perf_pkg.sv
package perf_pkg;
    localparam int CNT_W       = 32;
    localparam int NUM_CTR     = 2;
    localparam int SEL_W       = 5;
    localparam int NUM_CODES   = 31;
    localparam int CODE_CYCLES = 0;
    localparam int CODE_UNUSED = 29;
    localparam int REG_W       = CNT_W * NUM_CTR;
    localparam int CTRL_W      = 2 * SEL_W + 3;

    typedef enum logic {
        REG_COUNT = 1'b0,
        REG_CTRL  = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        CT_HOLD = 2'd0,
        CT_STEP = 2'd1,
        CT_LOAD = 2'd2
    } ctr_action_e;

    typedef struct packed {
        logic             glb_en;
        logic             krn_en;
        logic             usr_en;
        logic [SEL_W-1:0] sel1;
        logic [SEL_W-1:0] sel0;
    } ctrl_t;
endpackage

// File: rtl/perf_ctrl_reg.sv
module perf_ctrl_reg
    import perf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_val,
    output ctrl_t             ctrl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= ctrl_t'(wr_val);
    end

    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == ctrl_t'($past(wr_val))));
endmodule

// File: rtl/perf_event_sel.sv
module perf_event_sel
    import perf_pkg::*;
#(
    parameter int CODE_W  = SEL_W,
    parameter int N_CODES = NUM_CODES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  code,
    input  logic [N_CODES-1:0] strobe,
    input  logic               mode_ok,
    output logic               inc
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        if (code == CODE_W'(CODE_CYCLES))
            hit = 1'b1;
        else if (code == CODE_W'(CODE_UNUSED) || int'(code) >= N_CODES)
            hit = 1'b0;
        else
            hit = strobe[code];
    end

    assign inc = hit & mode_ok;

    assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_W'(CODE_UNUSED) || int'(code) >= N_CODES) |-> !inc);
    assert_filter_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |-> !inc);
endmodule

// File: rtl/perf_counter.sv
module perf_counter
    import perf_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] cnt_q
);
    ctr_action_e act;

    always_comb begin
        if (ld)       act = CT_LOAD;
        else if (inc) act = CT_STEP;
        else          act = CT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                CT_LOAD: cnt_q <= ld_val;
                CT_STEP: cnt_q <= cnt_q + W'(1);
                CT_HOLD: cnt_q <= cnt_q;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(ld_val)));
    assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && inc) |=> (cnt_q - $past(cnt_q) == W'(1)));
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc) |=> $stable(cnt_q));
    assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && inc && cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import perf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CODES-1:0] ev_strobe,
    input  logic                 priv_kernel,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);
    ctrl_t            ctrl_q;
    logic             wr_count;
    logic             wr_ctrl;
    logic             mode_ok;
    logic [SEL_W-1:0] sel   [NUM_CTR];
    logic [CNT_W-1:0] cnt_q [NUM_CTR];
    logic [NUM_CTR-1:0] inc;
    logic [NUM_CTR-1:0] msb;
    logic [REG_W-1:0] count_word;

    assign wr_count = reg_wr && (reg_sel_e'(reg_addr) == REG_COUNT);
    assign wr_ctrl  = reg_wr && (reg_sel_e'(reg_addr) == REG_CTRL);
    assign mode_ok  = ctrl_q.glb_en & (priv_kernel ? ctrl_q.krn_en : ctrl_q.usr_en);
    assign sel[0]   = ctrl_q.sel0;
    assign sel[1]   = ctrl_q.sel1;

    perf_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctrl),
        .wr_val (reg_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        perf_event_sel #(.CODE_W(SEL_W), .N_CODES(NUM_CODES)) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .code    (sel[i]),
            .strobe  (ev_strobe),
            .mode_ok (mode_ok),
            .inc     (inc[i])
        );
        perf_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (wr_count),
            .ld_val (reg_wdata[i*CNT_W +: CNT_W]),
            .inc    (inc[i]),
            .cnt_q  (cnt_q[i])
        );
        assign count_word[i*CNT_W +: CNT_W] = cnt_q[i];
        assign msb[i] = cnt_q[i][CNT_W-1];
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            REG_COUNT: reg_rdata = count_word;
            REG_CTRL:  reg_rdata = REG_W'(ctrl_q);
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |msb;

    assert_frozen_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.glb_en && !wr_count) |=> $stable(count_word));
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_count && !(|inc)) |=> (irq == $past(irq)));
endmodule

// File: tb/tb_perf_counter_unit.sv
`timescale 1ns/100ps
module tb_perf_counter_unit;
    localparam int NC = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ev_strobe = '0;
    logic          priv_kernel = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_c0, m_c1;
    logic [12:0] m_ctrl;

    always #2 clk = ~clk;

    perf_counter_unit dut (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .priv_kernel(priv_kernel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic bit f_hit(logic [4:0] code, logic [NC-1:0] s);
        if (code == 5'd0) return 1'b1;
        if (code == 5'd29 || code == 5'd31) return 1'b0;
        return s[code];
    endfunction

    function automatic bit f_qual(logic [12:0] c, logic pk);
        return c[12] && (pk ? c[11] : c[10]);
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the model, then check all visible state.
    task automatic cycle(string tag, logic [NC-1:0] s, logic pk, logic wr, logic a, logic [63:0] wd);
        bit q;
        @(negedge clk);
        ev_strobe = s; priv_kernel = pk; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        q = f_qual(m_ctrl, pk);
        if (wr && !a) begin
            m_c0 = wd[31:0]; m_c1 = wd[63:32];
        end else begin
            if (q && f_hit(m_ctrl[4:0], s)) m_c0 = m_c0 + 1;
            if (q && f_hit(m_ctrl[9:5], s)) m_c1 = m_c1 + 1;
        end
        if (wr && a) m_ctrl = wd[12:0];
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0; reg_addr = 1'b0;
        #0.5;
        chk({tag, " count"}, reg_rdata, {m_c1, m_c0});
        chk({tag, " irq R9"}, {63'd0, irq}, {63'd0, m_c0[31] | m_c1[31]});
        reg_addr = 1'b1;
        #0.5;
        chk({tag, " ctrl R3"}, reg_rdata, {51'd0, m_ctrl});
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_c0 = 0; m_c1 = 0; m_ctrl = 0;
        #1;
        reg_addr = 1'b0; #0.5;
        chk("R1 reset count", reg_rdata, 64'd0);
        chk("R1 reset irq", {63'd0, irq}, 64'd0);
        reg_addr = 1'b1; #0.5;
        chk("R1 reset ctrl", reg_rdata, 64'd0);
        #5 rst_n = 1'b1;

        // R7: disabled by default, strobes ignored
        cycle("R7 off", '1, 1'b0, 1'b0, 1'b0, 64'd0);
        // R3: reserved bits dropped on write
        cycle("R3 reserved", '0, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_E000 | 64'h1C00 | (64'd7 << 5));
        // R4: code 0 counts with strobes low; R5 counter 1 code 7
        cycle("R4 cycles", '0, 1'b0, 1'b0, 1'b0, 64'd0);
        cycle("R5 code7", 31'd1 << 7, 1'b1, 1'b0, 1'b0, 64'd0);
        cycle("R5 wrong bit", 31'd1 << 6, 1'b1, 1'b0, 1'b0, 64'd0);
        // R7: user only, kernel cycle blocked
        cycle("R7 set user", '0, 1'b0, 1'b1, 1'b1, 64'h1400);
        cycle("R7 kernel blocked", '1, 1'b1, 1'b0, 1'b0, 64'd0);
        cycle("R7 user counts", '1, 1'b0, 1'b0, 1'b0, 64'd0);
        // R6: codes 29 and 31 never count
        cycle("R6 set", '0, 1'b0, 1'b1, 1'b1, 64'h1C00 | (64'd31 << 5) | 64'd29);
        cycle("R6 quiet", '1, 1'b0, 1'b0, 1'b0, 64'd0);
        cycle("R6 quiet k", '1, 1'b1, 1'b0, 1'b0, 64'd0);
        // R2/R9: preload near top bit, step over to raise irq
        cycle("R2 set", '0, 1'b0, 1'b1, 1'b1, 64'h1C00 | (64'd9 << 5) | 64'd0);
        cycle("R2 load", '0, 1'b0, 1'b1, 1'b0, {32'h0000_0005, 32'h7FFF_FFFF});
        cycle("R9 rise", '0, 1'b0, 1'b0, 1'b0, 64'd0);
        // R10: wrap drops irq
        cycle("R10 load", '0, 1'b0, 1'b1, 1'b0, {32'h0000_0000, 32'hFFFF_FFFF});
        cycle("R10 wrap", '0, 1'b0, 1'b0, 1'b0, 64'd0);
        // R8: write beats increment
        cycle("R8 wr vs inc", '1, 1'b0, 1'b1, 1'b0, {32'h1234_5678, 32'h0000_0042});
        // R11: counter 1 on code 9, strobe only 9
        cycle("R11 indep", 31'd1 << 9, 1'b0, 1'b0, 1'b0, 64'd0);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [NC-1:0] s;
            logic pk, wr, a;
            logic [63:0] wd;
            s  = NC'($urandom);
            pk = 1'($urandom);
            wr = ($urandom_range(0, 15) == 0);
            a  = 1'($urandom);
            wd = {$urandom, $urandom};
            if (wr && a) wd[12] = ($urandom_range(0, 3) != 0);
            if (wr && !a && $urandom_range(0, 1) == 1) begin
                wd[31:0]  = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
                wd[63:32] = 32'h7FFF_FFF0 | 32'($urandom_range(0, 15));
            end
            cycle("R5 R11 random", s, pk, wr, a, wd);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule